// File: doc/BRIEF.md
# Instruction Fetch Read Slave with Abort Handling

This block answers instruction-fetch read requests from a single master. The master presents a request strobe together with a word address, a two-bit priority and a one-bit attribute. The slave waits a programmable number of cycles, acknowledges the address with a one-cycle pulse, and later returns a fixed burst of words, each marked by a read-data acknowledge. The word contents are generated from the captured request fields, so no memory array is needed.

The master may abort a request for as long as the request strobe is high. If the abort lands before the address acknowledge, or in the same cycle as it, the request is dropped and returns no data. Behind the burst that is in progress the slave can hold one further acknowledged request. A request that is aborted while an earlier burst is still streaming leaves that earlier burst untouched.

Top module: `fetch_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, with no request presented, both `addrAck` and `rdAck` are low.
- R2: `addrAck` is combinational and pulses in exactly one cycle. With the hold slot free, that is the cycle `cfgWait` cycles after the first cycle of the request, so a wait of 0 acknowledges in the first cycle. While the hold slot is occupied, the wait count starts only in the first cycle after the slot frees.
- R3: `reqAbort` has no effect while `reqValid` is low. A later request is then acknowledged and served as if the abort pulse had never happened.
- R4: A request aborted before its address acknowledge gets no `addrAck` and no `rdAck`.
- R5: A request whose abort falls in the same cycle as its `addrAck` gets no `rdAck`. No `rdAck` is ever issued without an accepted burst still owed.
- R6: An accepted request gets exactly BURST (default 4) `rdAck` pulses in consecutive cycles. The first pulse comes DATA_LAT (default 2) cycles after its `addrAck` when no earlier burst is streaming.
- R7: Each returned word carries the priority in bits [31:30] and the attribute in bit 29, with bits [28:16] zero. Bits [15:0] hold the request address plus the beat number (0 to BURST-1), modulo 2^16. With default widths, the address steps by one between consecutive beats of a burst.
- R8: At most one acknowledged request waits behind the active burst, and `addrAck` stays low while that slot is occupied. A queued request starts its first beat DATA_LAT cycles after the last beat of the burst ahead of it.
- R9: Aborting a pipelined request, either before its acknowledge or in the same cycle, while an earlier burst is streaming, leaves every beat of the earlier burst unchanged in value and timing.
- R10: Address, priority and attribute are captured in the `addrAck` cycle. Changes to them in later cycles do not alter the returned words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWait | input | 2 | Address-acknowledge wait, 0 to 3 cycles |
| reqValid | input | 1 | Fetch request strobe |
| reqAddr | input | 16 | Word address of the request |
| reqPrio | input | 2 | Request priority (3 highest) |
| reqAttr | input | 1 | User storage attribute of the target |
| reqAbort | input | 1 | Abort of the current request, qualified by reqValid |
| addrAck | output | 1 | Address acknowledge pulse |
| rdAck | output | 1 | Read-data acknowledge, one per returned word |
| rdData | output | 32 | Returned word, valid when rdAck is high |

## Verification
The address acknowledge is due in the same cycle as its qualifying inputs, `cfgWait` cycles after the later of two cycles: the first cycle of the request and the first cycle after the hold slot frees. The driver works out that cycle before it presents the request and compares `addrAck` against it in every cycle the request is held. Each beat is due DATA_LAT cycles after the later of its own acknowledge and the previous burst's last beat, and then once per cycle. The driver schedules each beat into a scoreboard with its cycle number and value. A monitor samples on the falling clock edge and fails any beat that comes early, late, with the wrong value, or with no expected entry. This is how aborted requests are shown to return nothing.

// File: rtl/fetch_slave_pkg.sv
package fetch_slave_pkg;

  // Load strobes from the control path to the request registers.
  typedef struct packed {
    logic loadCurFromReq;   // active burst takes the presented request
    logic loadCurFromPend;  // active burst takes the held request
    logic loadPendFromReq;  // hold slot takes the presented request
  } fsStrobe_t;

endpackage

// File: rtl/fetch_slave_ctrl.sv
module fetch_slave_ctrl
  import fetch_slave_pkg::*;
#(
  parameter int WAIT_W   = 2,
  parameter int BURST    = 4,
  parameter int DATA_LAT = 2,
  localparam int BEAT_W  = (BURST > 1) ? $clog2(BURST) : 1,
  localparam int LAT_W   = $clog2(DATA_LAT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              reqValid,
  input  logic              reqAbort,
  output logic              addrAck,
  output logic              rdAck,
  output logic [BEAT_W-1:0] beatIdx,
  output fsStrobe_t         strobe
);

  logic [WAIT_W-1:0] waitCnt;
  logic              pendValid;
  logic              active;
  logic [LAT_W-1:0]  latCnt;
  logic [BEAT_W-1:0] beatCnt;

  logic waitDone, accept, beatNow, lastBeat, engFree, loadCur;

  // Address phase: acknowledge once the wait has elapsed with the slot free.
  assign waitDone = (waitCnt >= cfgWait);
  assign addrAck  = reqValid && !pendValid && waitDone;
  // An abort in the acknowledge cycle cancels the transfer outright.
  assign accept   = addrAck && !reqAbort;

  // Data phase bookkeeping.
  assign beatNow  = active && (latCnt == '0);
  assign lastBeat = (beatCnt == BEAT_W'(BURST - 1));
  assign engFree  = !active || (beatNow && lastBeat);

  always_comb begin
    strobe = '0;
    if (pendValid && engFree) begin
      strobe.loadCurFromPend = 1'b1;
    end else if (accept && engFree) begin
      strobe.loadCurFromReq = 1'b1;
    end else if (accept) begin
      strobe.loadPendFromReq = 1'b1;
    end
  end

  assign loadCur = strobe.loadCurFromReq || strobe.loadCurFromPend;

  // Wait counter: runs only while a live request sees a free slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (!reqValid || reqAbort || addrAck) begin
      waitCnt <= '0;
    end else if (!pendValid && !waitDone) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  // Single-entry hold slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
    end else if (strobe.loadCurFromPend) begin
      pendValid <= 1'b0;
    end else if (strobe.loadPendFromReq) begin
      pendValid <= 1'b1;
    end
  end

  // Burst engine: latency countdown, then one beat per cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      latCnt  <= '0;
      beatCnt <= '0;
    end else if (loadCur) begin
      active  <= 1'b1;
      latCnt  <= LAT_W'(DATA_LAT - 1);
      beatCnt <= '0;
    end else if (beatNow) begin
      if (lastBeat) begin
        active <= 1'b0;
      end else begin
        beatCnt <= beatCnt + 1'b1;
      end
    end else if (active) begin
      latCnt <= latCnt - 1'b1;
    end
  end

  assign rdAck   = beatNow;
  assign beatIdx = beatCnt;

endmodule

// File: rtl/fetch_slave_dp.sv
module fetch_slave_dp
  import fetch_slave_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BEAT_W  = 2,
  localparam int PAD_W  = DATA_W - ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsStrobe_t         strobe,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqPrio,
  input  logic              reqAttr,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] curAddr, pendAddr;
  logic [1:0]        curPrio, pendPrio;
  logic              curAttr, pendAttr;
  logic [ADDR_W-1:0] wordAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendPrio <= '0;
      pendAttr <= 1'b0;
    end else if (strobe.loadPendFromReq) begin
      pendAddr <= reqAddr;
      pendPrio <= reqPrio;
      pendAttr <= reqAttr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      curPrio <= '0;
      curAttr <= 1'b0;
    end else if (strobe.loadCurFromPend) begin
      curAddr <= pendAddr;
      curPrio <= pendPrio;
      curAttr <= pendAttr;
    end else if (strobe.loadCurFromReq) begin
      curAddr <= reqAddr;
      curPrio <= reqPrio;
      curAttr <= reqAttr;
    end
  end

  assign wordAddr = curAddr + ADDR_W'(beatIdx);

  // Generated word: tag bits on top, running word address at the bottom.
  generate
    if (PAD_W > 0) begin : g_pad
      assign rdData = {curPrio, curAttr, {PAD_W{1'b0}}, wordAddr};
    end else begin : g_nopad
      assign rdData = {curPrio, curAttr, wordAddr};
    end
  endgenerate

endmodule

// File: rtl/fetch_slave.sv
module fetch_slave
  import fetch_slave_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int WAIT_W   = 2,
  parameter int BURST    = 4,
  parameter int DATA_LAT = 2,
  localparam int BEAT_W  = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqPrio,
  input  logic              reqAttr,
  input  logic              reqAbort,
  output logic              addrAck,
  output logic              rdAck,
  output logic [DATA_W-1:0] rdData
);

  fsStrobe_t         strobe;
  logic [BEAT_W-1:0] beatIdx;

  fetch_slave_ctrl #(
    .WAIT_W(WAIT_W), .BURST(BURST), .DATA_LAT(DATA_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWait(cfgWait),
    .reqValid(reqValid), .reqAbort(reqAbort),
    .addrAck(addrAck), .rdAck(rdAck),
    .beatIdx(beatIdx), .strobe(strobe)
  );

  fetch_slave_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatIdx(beatIdx),
    .reqAddr(reqAddr), .reqPrio(reqPrio), .reqAttr(reqAttr),
    .rdData(rdData)
  );

endmodule

// File: rtl/fetch_slave_chk.sv
module fetch_slave_chk #(
  parameter int ADDR_W  = 16,
  parameter int BURST   = 4,
  localparam int OUT_W  = $clog2(2 * BURST + 1) + 1,
  localparam int POS_W  = (BURST > 1) ? $clog2(BURST) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqAbort,
  input logic              addrAck,
  input logic              rdAck,
  input logic [ADDR_W-1:0] rdLow
);

  // Beats still owed, derived from port activity only.
  logic [OUT_W-1:0] owed;
  logic [POS_W-1:0] beatPos;
  logic             taken;

  assign taken = addrAck && reqValid && !reqAbort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owed    <= '0;
      beatPos <= '0;
    end else begin
      owed <= owed + (taken ? OUT_W'(BURST) : '0) - (rdAck ? OUT_W'(1) : '0);
      if (rdAck) begin
        beatPos <= (beatPos == POS_W'(BURST - 1)) ? '0 : beatPos + 1'b1;
      end
    end
  end

  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> reqValid);

  a_r8_one_waiting: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> (owed <= OUT_W'(BURST)));

  a_r5_no_unowed_data: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> (owed != '0));

  a_r6_burst_unbroken: assert property (@(posedge clk) disable iff (!rstN)
    (beatPos != '0) |-> rdAck);

  a_r7_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && beatPos != '0) |-> (rdLow == $past(rdLow) + 1'b1));

endmodule

bind fetch_slave fetch_slave_chk #(.ADDR_W(ADDR_W), .BURST(BURST)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAbort(reqAbort),
  .addrAck(addrAck), .rdAck(rdAck), .rdLow(rdData[ADDR_W-1:0])
);

// File: tb/test_fetch_slave.sv
`timescale 1ns/1ps
module test_fetch_slave;

  localparam int BURST = 4;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgWait = 2'd0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqPrio = '0;
  logic        reqAttr = 1'b0;
  logic        reqAbort = 1'b0;
  logic        addrAck, rdAck;
  logic [31:0] rdData;

  fetch_slave i_fetch_slave (
    .clk(clk), .rstN(rstN), .cfgWait(cfgWait), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqPrio(reqPrio), .reqAttr(reqAttr),
    .reqAbort(reqAbort), .addrAck(addrAck), .rdAck(rdAck), .rdData(rdData)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;

  typedef struct { int due; logic [31:0] word; } beat_t;
  beat_t expQ[$];

  int lastBeat = -100;
  int slotBusyUntil = -100;

  function automatic logic [31:0] mkWord(logic [15:0] a, logic [1:0] p, logic at, int k);
    logic [31:0] w;
    w = '0;
    w[31:30] = p;
    w[29] = at;
    w[15:0] = a + 16'(k);
    return w;
  endfunction

  // Monitor: pops the scoreboard as beats appear.
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() > 0 && expQ[0].due < cyc) begin
        checks++; failures++;
        $display("FAIL R6 missed beat: actual none at %0d expected beat due %0d", cyc, expQ[0].due);
        void'(expQ.pop_front());
      end
      if (rdAck) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R5 unowed rdAck: actual data %h at %0d expected no beat", rdData, cyc);
        end else begin
          beat_t b;
          b = expQ.pop_front();
          if (b.due != cyc || b.word !== rdData) begin
            failures++;
            $display("FAIL R6/R7/R10 beat: actual %h at %0d expected %h at %0d",
                     rdData, cyc, b.word, b.due);
          end
        end
      end
    end
  end

  // Driver. mode 0: no abort, 1: abort in first cycle, 2: abort in ack cycle.
  task automatic doReq(input logic [15:0] a, input logic [1:0] p, input logic at,
                       input int mode, input string tag);
    int eligible, expAck, ackCyc, first;
    bit done;
    @(posedge clk); #1;
    eligible = (cyc > slotBusyUntil) ? cyc : slotBusyUntil + 1;
    expAck = eligible + int'(cfgWait);
    ackCyc = -1;
    done = 0;
    reqValid = 1'b1; reqAddr = a; reqPrio = p; reqAttr = at;
    for (int i = 0; i < 40 && !done; i++) begin
      reqAbort = (mode == 1 && i == 0) || (mode == 2 && cyc == expAck);
      @(negedge clk);
      if (addrAck && ackCyc < 0) ackCyc = cyc;
      if (reqAbort) begin
        done = 1;
      end else if (addrAck) begin
        first = ((cyc > lastBeat) ? cyc : lastBeat) + LAT;
        if (cyc < lastBeat) slotBusyUntil = lastBeat;
        for (int k = 0; k < BURST; k++) expQ.push_back('{first + k, mkWord(a, p, at, k)});
        lastBeat = first + BURST - 1;
        done = 1;
      end else begin
        @(posedge clk); #1;
      end
    end
    checks++;
    if (mode == 1) begin
      if (ackCyc != -1) begin
        failures++;
        $display("FAIL R4 %s early abort: actual ack at %0d expected none", tag, ackCyc);
      end
    end else if (ackCyc != expAck) begin
      failures++;
      $display("FAIL R2 %s ack cycle: actual %0d expected %0d", tag, ackCyc, expAck);
    end
    @(posedge clk); #1;
    reqValid = 1'b0; reqAbort = 1'b0;
    reqAddr = ~a; reqPrio = ~p; reqAttr = ~at;  // R10: fields change after capture
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkDrained(input string tag);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s drain: actual %0d beats left expected 0", tag, expQ.size());
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (addrAck !== 1'b0 || rdAck !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: actual ack=%b rd=%b expected 0 0", addrAck, rdAck);
    end
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (addrAck !== 1'b0 || rdAck !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset: actual ack=%b rd=%b expected 0 0", addrAck, rdAck);
    end

    // R2/R6/R7: plain requests at several wait settings
    cfgWait = 2'd0; doReq(16'h1000, 2'd3, 1'b0, 0, "R2 w0"); idle(10);
    cfgWait = 2'd3; doReq(16'hFFFE, 2'd1, 1'b1, 0, "R2 w3 wrap"); idle(10);
    checkDrained("R6");

    // R3: abort pulse with no request
    cfgWait = 2'd1;
    @(posedge clk); #1; reqAbort = 1'b1;
    @(negedge clk);
    checks++;
    if (addrAck !== 1'b0 || rdAck !== 1'b0) begin
      failures++;
      $display("FAIL R3 idle abort: actual ack=%b rd=%b expected 0 0", addrAck, rdAck);
    end
    @(posedge clk); #1; reqAbort = 1'b0;
    doReq(16'h2220, 2'd2, 1'b1, 0, "R3 follow"); idle(10);
    checkDrained("R3");

    // R4: abort before acknowledge
    cfgWait = 2'd2; doReq(16'h3330, 2'd0, 1'b0, 1, "R4"); idle(10);
    checkDrained("R4");

    // R5: abort coinciding with acknowledge
    cfgWait = 2'd0; doReq(16'h4440, 2'd3, 1'b1, 2, "R5 w0"); idle(4);
    cfgWait = 2'd2; doReq(16'h4450, 2'd2, 1'b0, 2, "R5 w2"); idle(10);
    checkDrained("R5");

    // R8: pipelined requests, third blocked by the full slot
    cfgWait = 2'd0;
    doReq(16'h5000, 2'd1, 1'b0, 0, "R8 A");
    doReq(16'h5100, 2'd2, 1'b1, 0, "R8 B");
    doReq(16'h5200, 2'd3, 1'b0, 0, "R8 C");
    doReq(16'h5300, 2'd0, 1'b1, 1, "R8 D aborted while slot busy");
    idle(25);
    checkDrained("R8");

    // R9: aborted pipelined requests during an earlier burst
    cfgWait = 2'd2;
    doReq(16'h6000, 2'd3, 1'b1, 0, "R9 A");
    doReq(16'h6100, 2'd1, 1'b0, 1, "R9 early");
    doReq(16'h6200, 2'd2, 1'b1, 2, "R9 at ack");
    idle(20);
    checkDrained("R9");

    // R10: mixed fields, captured values must stick
    cfgWait = 2'd1;
    doReq(16'h7777, 2'd0, 1'b1, 0, "R10 a");
    doReq(16'h8888, 2'd3, 1'b0, 0, "R10 b");
    idle(25);
    checkDrained("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual still running at %0d expected finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule